// File: doc/BRIEF.md
# Serial GPIO Master

This block extends a chip's general-purpose I/O through an external chain of shift registers. It uses four wires: a serial clock, a load strobe, a data line toward the chain and a data line back from it. Each exchange is a frame. A frame first gives one load period. Then, in every serial bit slot, one output bit goes out and one input bit comes in. Software sets the bus-clock divider, the frame length and the receive policy through an APB-style register slave. It fills the transmit words and starts a frame by writing a trigger bit. It learns that the frame has finished from a busy flag or from an interrupt.

A frame controller steps through these states. `IDLE` waits for a trigger. `LOAD_A` and `LOAD_B` are the low and high halves of the load period. `BIT_LO` and `BIT_HI` are the low and high halves of each data slot. `FINISH` is a single bus cycle that commits the received data and raises the interrupt. `GAP` is the pause between frames in repeat mode. The transitions are:
- `IDLE`→`LOAD_A` on an accepted trigger.
- `LOAD_A`→`LOAD_B`→`BIT_LO` on divider ticks.
- `BIT_LO`→`BIT_HI` on a tick, sampling the input.
- `BIT_HI`→`BIT_LO` on a tick, or `BIT_HI`→`FINISH` on a tick after the last slot.
- `FINISH`→`IDLE` in one-shot mode. In repeat mode, `FINISH`→`GAP`, or `FINISH`→`LOAD_A` when the gap length is zero.
- `GAP`→`LOAD_A` once the gap has elapsed, or `GAP`→`IDLE` when repeat mode has been cleared.
- Any state →`IDLE` on soft reset or when the block is disabled.

Top module: `sgpio_master`

## Requirements
- R1: After reset, every register reads 0, `ser_clk_o` is high, `ser_load_o` and `ser_dout_o` are low and `irq_o` is low.
- R2: The configuration register at 0x00 reads back its fields: enable in bit 0, receive-off in bit 1, a 4-bit pattern in bits 11:8 and the divider in bits 31:12, with the other bits reading 0. The frame register at 0x04 reads back repeat mode in bit 2, the bit count in bits 14:8 and the gap length in bits 31:16. In that register, bit 1 (trigger) always reads 0, bit 3 reads busy and bit 0 reads ready, which is enable AND NOT busy.
- R3: During a frame, the serial clock has a period of 2·(divider+1) bus cycles, with one half low and one half high. The serial clock idles high.
- R4: Each frame begins with the load strobe high for exactly one serial period, 2·(divider+1) bus cycles, before the first data slot.
- R5: A frame holds 32·W data slots. W is bits 6:5 of the bit count, with 0 treated as 1. Bits 4:0 of the count are ignored.
- R6: Output bits leave in this order: bit 0 of the first transmit word first, through to the top bit of the last used word. The transmit words sit at 0x14, 0x18 and 0x20. The output changes with the falling serial clock and is stable at the rising edge.
- R7: The input is sampled at each rising serial edge. Slot k lands in read word k/32, bit k%32, and the read words sit at 0x24, 0x28 and 0x2C. The read words are updated at the end of the frame, and words beyond the frame length read 0.
- R8: When receive-off is set, the read words keep their previous value across a frame.
- R9: Writing 1 to the trigger bit while the block is enabled and idle starts one frame. Busy reads 1 during the frame and 0 after it. A trigger while busy, or while the block is disabled, starts nothing.
- R10: Bit 0 at 0x0C is set at the end of every frame. A write to 0x0C with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. When bit 0 at 0x10 is 1, `irq_o` is held low. Otherwise `irq_o` follows the status bit.
- R11: Writing 1 to bit 0 at 0x08 returns the controller to idle and clears busy and the interrupt status. The configuration registers keep their values.
- R12: In repeat mode, frames repeat automatically. Let D = divider+1 and G = the gap length. From the last rising data edge of one frame to the rise of the next load strobe there are D+1+2·G·D bus cycles. Clearing repeat mode ends the sequence and returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Frame-done interrupt, after the mask |
| ser_clk_o | output | 1 | Serial clock to the chain |
| ser_load_o | output | 1 | Load strobe to the chain |
| ser_dout_o | output | 1 | Serial data to the chain |
| ser_din_i | input | 1 | Serial data from the chain |

## Verification
The hardest situations to reach from the ports are the ones that happen inside a running frame. These are a soft reset or a second trigger that arrives in the middle of the bit slots, and the exact spacing between repeated frames. The bench models the external chain. It watches the serial clock and load strobe every bus cycle, drives a new input bit after each falling edge and records the output bit at each rising edge. It issues register writes at chosen points within a frame and measures load widths, slot periods and the gap between frames in bus cycles. These measurements are compared against figures calculated from the divider and the gap length, swept over several dividers and bit counts.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD_A = 3'd1,
        ST_LOAD_B = 3'd2,
        ST_BIT_LO = 3'd3,
        ST_BIT_HI = 3'd4,
        ST_FINISH = 3'd5,
        ST_GAP    = 3'd6
    } seq_state_e;

    localparam logic [7:0] ADDR_CFG   = 8'h00;
    localparam logic [7:0] ADDR_FRAME = 8'h04;
    localparam logic [7:0] ADDR_SRST  = 8'h08;
    localparam logic [7:0] ADDR_ISTAT = 8'h0C;
    localparam logic [7:0] ADDR_IMASK = 8'h10;

    // Transmit words skip one slot after the second word.
    function automatic logic [7:0] tx_word_addr(input int k);
        return 8'(32'h14 + 32'(((k >= 2) ? k + 1 : k) * 4));
    endfunction

    function automatic logic [7:0] rx_word_addr(input int k);
        return 8'(32'h24 + 32'(k * 4));
    endfunction

endpackage

// File: rtl/sgpio_clkdiv.sv
module sgpio_clkdiv #(
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // A tick ends every half serial period; >= tolerates a shrinking divider.
    assign tick_o = run_i && (cnt_q >= div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: every half period starts from a cleared count
    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/sgpio_seq.sv
module sgpio_seq
    import sgpio_pkg::*;
#(
    parameter int NUM_WORDS  = 3,
    parameter int GAP_W      = 16,
    parameter int FRAME_BITS = NUM_WORDS * 32,
    parameter int IDX_W      = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  mode_i,
    input  logic [1:0]            words_i,
    input  logic [GAP_W-1:0]      gap_i,
    input  logic                  start_i,
    input  logic                  srst_i,
    input  logic                  tick_i,
    input  logic [FRAME_BITS-1:0] tx_frame_i,
    input  logic                  sdin_i,
    output logic                  run_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [FRAME_BITS-1:0] rx_frame_o,
    output logic                  sclk_o,
    output logic                  sload_o,
    output logic                  sdout_o
);

    seq_state_e st_q, st_d;

    logic [IDX_W-1:0]      idx_q;
    logic [IDX_W-1:0]      last_q;
    logic [IDX_W-1:0]      last_d;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic [GAP_W:0]        gap_cnt_q;
    logic [GAP_W:0]        gap_last;
    logic                  enter_frame;

    assign gap_last    = {gap_i, 1'b0} - 1'b1;
    assign enter_frame = (st_d == ST_LOAD_A) && (st_q != ST_LOAD_A);

    // Frame length in slots, clamped to the buffer size.
    always_comb begin
        int w;
        w = int'(words_i);
        if (w == 0) w = 1;
        if (w > NUM_WORDS) w = NUM_WORDS;
        last_d = IDX_W'(w * 32 - 1);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i && en_i) st_d = ST_LOAD_A;
            ST_LOAD_A: if (tick_i) st_d = ST_LOAD_B;
            ST_LOAD_B: if (tick_i) st_d = ST_BIT_LO;
            ST_BIT_LO: if (tick_i) st_d = ST_BIT_HI;
            ST_BIT_HI: if (tick_i) st_d = (idx_q == last_q) ? ST_FINISH : ST_BIT_LO;
            ST_FINISH: begin
                if (!mode_i)            st_d = ST_IDLE;
                else if (gap_i == '0)   st_d = ST_LOAD_A;
                else                    st_d = ST_GAP;
            end
            ST_GAP: begin
                if (!mode_i)                               st_d = ST_IDLE;
                else if (tick_i && gap_cnt_q == gap_last)  st_d = ST_LOAD_A;
            end
            default: st_d = ST_IDLE;
        endcase
        if (srst_i || !en_i) st_d = ST_IDLE;
    end

    // Line outputs and status decoded from the state.
    always_comb begin
        sclk_o  = 1'b1;
        sload_o = 1'b0;
        sdout_o = 1'b0;
        run_o   = 1'b0;
        done_o  = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_LOAD_A: begin sclk_o = 1'b0; sload_o = 1'b1; run_o = 1'b1; end
            ST_LOAD_B: begin sload_o = 1'b1; run_o = 1'b1; end
            ST_BIT_LO: begin sclk_o = 1'b0; sdout_o = tx_q[idx_q]; run_o = 1'b1; end
            ST_BIT_HI: begin sdout_o = tx_q[idx_q]; run_o = 1'b1; end
            ST_FINISH: done_o = 1'b1;
            ST_GAP:    run_o = 1'b1;
            default:   ;
        endcase
    end

    assign busy_o     = (st_q != ST_IDLE);
    assign rx_frame_o = rx_q;

    // Datapath: snapshot, slot index, capture, gap counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            last_q    <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            gap_cnt_q <= '0;
        end else begin
            if (enter_frame) begin
                tx_q   <= tx_frame_i;
                rx_q   <= '0;
                last_q <= last_d;
                idx_q  <= '0;
            end
            if (st_q == ST_BIT_LO && tick_i) begin
                rx_q[idx_q] <= sdin_i;
            end
            if (st_q == ST_BIT_HI && tick_i && idx_q != last_q) begin
                idx_q <= idx_q + 1'b1;
            end
            if (st_q == ST_FINISH) begin
                gap_cnt_q <= '0;
            end else if (st_q == ST_GAP && tick_i) begin
                gap_cnt_q <= gap_cnt_q + 1'b1;
            end
        end
    end

    // R9: an accepted trigger makes the block busy
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) && start_i && en_i && !srst_i |=> busy_o);

    // R9: a trigger inside the data slots does not restart the frame
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BIT_LO || st_q == ST_BIT_HI) && start_i |=> st_q != ST_LOAD_A);

    // R11: soft reset leaves the controller idle
    p_srst_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> !busy_o);

    // R5: slot index never passes the frame length
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BIT_LO || st_q == ST_BIT_HI) |-> idx_q <= last_q);

    // R6: data line holds through the low half of a slot
    p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BIT_LO) && !tick_i && en_i && !srst_i |=> $stable(sdout_o));

endmodule

// File: rtl/sgpio_regs.sv
module sgpio_regs
    import sgpio_pkg::*;
#(
    parameter int NUM_WORDS  = 3,
    parameter int DIV_W      = 20,
    parameter int CNT_W      = 7,
    parameter int GAP_W      = 16,
    parameter int FRAME_BITS = NUM_WORDS * 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [7:0]            paddr,
    input  logic [31:0]           pwdata,
    output logic [31:0]           prdata,
    input  logic                  busy_i,
    input  logic                  done_i,
    input  logic [FRAME_BITS-1:0] rx_frame_i,
    output logic                  en_o,
    output logic [DIV_W-1:0]      div_o,
    output logic                  mode_o,
    output logic [1:0]            words_o,
    output logic [GAP_W-1:0]      gap_o,
    output logic [FRAME_BITS-1:0] tx_frame_o,
    output logic                  start_o,
    output logic                  srst_o,
    output logic                  irq_o
);

    logic             wr;
    logic             en_q, rx_off_q, mode_q, istat_q, imask_q;
    logic [3:0]       pat_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [GAP_W-1:0] gap_q;
    logic [31:0]      wd_q [NUM_WORDS];
    logic [31:0]      rd_q [NUM_WORDS];
    logic [FRAME_BITS-1:0] rd_flat;

    assign wr      = psel && penable && pwrite;
    assign start_o = wr && (paddr == ADDR_FRAME) && pwdata[1] && en_q;
    assign srst_o  = wr && (paddr == ADDR_SRST) && pwdata[0];

    assign en_o    = en_q;
    assign div_o   = div_q;
    assign mode_o  = mode_q;
    assign words_o = cnt_q[6:5];
    assign gap_o   = gap_q;
    assign irq_o   = istat_q && !imask_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
        assign tx_frame_o[g*32 +: 32] = wd_q[g];
        assign rd_flat[g*32 +: 32]    = rd_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rx_off_q <= 1'b0;
            pat_q    <= '0;
            div_q    <= '0;
            mode_q   <= 1'b0;
            cnt_q    <= '0;
            gap_q    <= '0;
            imask_q  <= 1'b0;
        end else if (wr) begin
            unique case (paddr)
                ADDR_CFG: begin
                    en_q     <= pwdata[0];
                    rx_off_q <= pwdata[1];
                    pat_q    <= pwdata[11:8];
                    div_q    <= pwdata[12 +: DIV_W];
                end
                ADDR_FRAME: begin
                    mode_q <= pwdata[2];
                    cnt_q  <= pwdata[8 +: CNT_W];
                    gap_q  <= pwdata[16 +: GAP_W];
                end
                ADDR_IMASK: imask_q <= pwdata[0];
                default: ;
            endcase
        end
    end

    // Interrupt status: set by frame end, cleared by a zero write or soft reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        istat_q <= 1'b0;
        else if (srst_o)                                   istat_q <= 1'b0;
        else if (done_i)                                   istat_q <= 1'b1;
        else if (wr && paddr == ADDR_ISTAT && !pwdata[0])  istat_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                wd_q[k] <= '0;
                rd_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (wr && paddr == tx_word_addr(k)) wd_q[k] <= pwdata;
                if (done_i && !rx_off_q)            rd_q[k] <= rx_frame_i[k*32 +: 32];
            end
        end
    end

    always_comb begin
        prdata = '0;
        unique case (paddr)
            ADDR_CFG: begin
                prdata[0]            = en_q;
                prdata[1]            = rx_off_q;
                prdata[11:8]         = pat_q;
                prdata[12 +: DIV_W]  = div_q;
            end
            ADDR_FRAME: begin
                prdata[0]            = en_q && !busy_i;
                prdata[2]            = mode_q;
                prdata[3]            = busy_i;
                prdata[8 +: CNT_W]   = cnt_q;
                prdata[16 +: GAP_W]  = gap_q;
            end
            ADDR_ISTAT: prdata[0] = istat_q;
            ADDR_IMASK: prdata[0] = imask_q;
            default: ;
        endcase
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (paddr == tx_word_addr(k)) prdata = wd_q[k];
            if (paddr == rx_word_addr(k)) prdata = rd_q[k];
        end
    end

    // R10: a frame end always leaves the status set
    p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !srst_o |=> istat_q);

    // R8: receive-off freezes the read words
    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_off_q |=> $stable(rd_flat));

    // R11: soft reset keeps configuration
    p_srst_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> $stable(div_q) && $stable(en_q) && $stable(cnt_q) && !istat_q);

endmodule

// File: rtl/sgpio_master.sv
module sgpio_master #(
    parameter int NUM_WORDS = 3,
    parameter int DIV_W     = 20,
    parameter int CNT_W     = 7,
    parameter int GAP_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [7:0]  paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        irq_o,
    output logic        ser_clk_o,
    output logic        ser_load_o,
    output logic        ser_dout_o,
    input  logic        ser_din_i
);

    localparam int FRAME_BITS = NUM_WORDS * 32;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    logic                  en, mode, start, srst, busy, done, run, tick;
    logic [DIV_W-1:0]      div;
    logic [1:0]            words;
    logic [GAP_W-1:0]      gap;
    logic [FRAME_BITS-1:0] tx_frame, rx_frame;

    sgpio_regs #(
        .NUM_WORDS(NUM_WORDS), .DIV_W(DIV_W), .CNT_W(CNT_W),
        .GAP_W(GAP_W), .FRAME_BITS(FRAME_BITS)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .busy_i(busy), .done_i(done), .rx_frame_i(rx_frame),
        .en_o(en), .div_o(div), .mode_o(mode), .words_o(words), .gap_o(gap),
        .tx_frame_o(tx_frame), .start_o(start), .srst_o(srst), .irq_o(irq_o)
    );

    sgpio_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div), .tick_o(tick)
    );

    sgpio_seq #(
        .NUM_WORDS(NUM_WORDS), .GAP_W(GAP_W),
        .FRAME_BITS(FRAME_BITS), .IDX_W(IDX_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .words_i(words),
        .gap_i(gap), .start_i(start), .srst_i(srst), .tick_i(tick),
        .tx_frame_i(tx_frame), .sdin_i(ser_din_i), .run_o(run),
        .busy_o(busy), .done_o(done), .rx_frame_o(rx_frame),
        .sclk_o(ser_clk_o), .sload_o(ser_load_o), .sdout_o(ser_dout_o)
    );

endmodule

// File: tb/sgpio_master_tb_top.sv
`timescale 1ns/1ps
module sgpio_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o, ser_clk, ser_load, ser_dout;
    logic        ser_din = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sgpio_master dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_o(irq_o), .ser_clk_o(ser_clk), .ser_load_o(ser_load),
        .ser_dout_o(ser_dout), .ser_din_i(ser_din)
    );

    // External chain model and timing monitor.
    int cyc = 0, frames = 0, nbits = 0, last_rise = 0, load_rise = 0;
    int load_width = 0, per_min = 0, per_max = 0, gap_meas = 0;
    logic [127:0] tx_cap = '0;
    logic [127:0] din_pat = '0;
    logic sclk_p = 1'b1, load_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (ser_load && !load_p) begin
            frames++;
            gap_meas  = cyc - last_rise;
            load_rise = cyc;
            nbits     = 0;
            per_min   = 1000000;
            per_max   = 0;
        end
        if (!ser_load && load_p) load_width = cyc - load_rise;
        if (!ser_load && ser_clk && !sclk_p) begin
            if (nbits < 128) tx_cap[nbits] = ser_dout;
            if (nbits > 0) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            nbits++;
            last_rise = cyc;
        end
        if (!ser_load && !ser_clk && sclk_p) ser_din = (nbits < 128) ? din_pat[nbits] : 1'b0;
        sclk_p = ser_clk;
        load_p = ser_load;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic mon_clear();
        @(posedge clk); #1;
        frames = 0; nbits = 0; tx_cap = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 4000; i++) begin
            apb_rd(8'h04, d);
            if (!d[3]) break;
        end
    endtask

    function automatic logic [7:0] waddr(input int k);
        return (k == 2) ? 8'h20 : 8'(8'h14 + k * 4);
    endfunction

    logic [31:0] rd_model [3] = '{32'h0, 32'h0, 32'h0};

    task automatic run_frame(input int div, input int cnt, input int seed, input bit rxoff);
        logic [31:0] w [3];
        logic [31:0] d;
        int nb, dd;
        dd = div + 1;
        nb = ((cnt >> 5) == 0) ? 32 : (cnt >> 5) * 32;
        for (int k = 0; k < 3; k++) begin
            w[k] = (32'(seed * 3 + k + 1) * 32'h9E3779B9) ^ 32'h0F0F33CC;
            apb_wr(waddr(k), w[k]);
        end
        din_pat = {w[0] ^ 32'hFFFF0000, ~w[2], w[1] + 32'd7, w[0] ^ 32'h13579BDF};
        apb_wr(8'h00, (32'(div) << 12) | 32'h600 | (32'(rxoff) << 1) | 32'h1);
        apb_wr(8'h04, 32'(cnt) << 8);
        mon_clear();
        apb_wr(8'h04, (32'(cnt) << 8) | 32'h2);
        wait_idle();
        chk("R9 one frame per trigger", frames, 1);
        chk("R5 slot count", nbits, nb);
        chk("R4 load width", load_width, 2 * dd);
        if (nb > 1) begin
            chk("R3 min period", per_min, 2 * dd);
            chk("R3 max period", per_max, 2 * dd);
        end
        for (int k = 0; k < 3; k++) begin
            if (k * 32 < nb) chk("R6 tx order", tx_cap[k*32 +: 32], w[k]);
            if (!rxoff) rd_model[k] = (k * 32 < nb) ? din_pat[k*32 +: 32] : 32'h0;
            apb_rd(8'(8'h24 + k * 4), d);
            chk(rxoff ? "R8 rx frozen" : "R7 rx capture", d, rd_model[k]);
        end
        apb_rd(8'h0C, d);
        chk("R10 status set at end", d, 32'h1);
        chk("R10 irq out", {31'b0, irq_o}, 32'h1);
        apb_wr(8'h0C, 32'h0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #3000000;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        apb_rd(8'h00, d); chk("R1 cfg reset", d, 0);
        apb_rd(8'h04, d); chk("R1 frame reset", d, 0);
        apb_rd(8'h0C, d); chk("R1 status reset", d, 0);
        apb_rd(8'h24, d); chk("R1 read word reset", d, 0);
        chk("R1 lines idle", {28'b0, ser_clk, ser_load, ser_dout, irq_o}, 32'h8);

        // R2 readback
        apb_wr(8'h00, 32'hABCDE7FF);
        apb_rd(8'h00, d); chk("R2 cfg readback", d, 32'hABCDE703);
        apb_wr(8'h04, 32'hBEEF7F04);
        apb_rd(8'h04, d); chk("R2 frame readback", d, 32'hBEEF7F05);
        apb_wr(8'h04, 32'h0);
        apb_wr(8'h00, 32'h0);

        // Sweep dividers and bit counts (R3..R7, R9, R10)
        for (int dv = 0; dv < 3; dv++) begin
            for (int ci = 0; ci < 6; ci++) begin
                int cnts [6] = '{0, 32, 40, 64, 96, 127};
                run_frame(dv, cnts[ci], dv * 6 + ci, 1'b0);
            end
        end

        // R8 receive-off
        run_frame(1, 96, 77, 1'b1);

        // R9 trigger while busy ignored, busy visible
        apb_wr(8'h00, (32'd2 << 12) | 32'h1);
        mon_clear();
        apb_wr(8'h04, (32'd32 << 8) | 32'h2);
        repeat (30) @(negedge clk);
        apb_rd(8'h04, d); chk("R9 busy during frame", {30'b0, d[3], d[0]}, 32'h2);
        apb_wr(8'h04, (32'd32 << 8) | 32'h2);
        wait_idle();
        repeat (300) @(negedge clk);
        chk("R9 retrigger ignored", frames, 1);
        apb_rd(8'h04, d); chk("R9 idle after", {30'b0, d[3], d[0]}, 32'h1);

        // R10 mask and clear rules (status is set from the frame above)
        apb_wr(8'h10, 32'h1);
        chk("R10 masked irq", {31'b0, irq_o}, 0);
        apb_rd(8'h0C, d); chk("R10 status under mask", d, 1);
        apb_wr(8'h10, 32'h0);
        chk("R10 unmasked irq", {31'b0, irq_o}, 1);
        apb_wr(8'h0C, 32'h1);
        apb_rd(8'h0C, d); chk("R10 write one keeps", d, 1);

        // R11 soft reset mid-frame, status still set
        apb_wr(8'h00, (32'd3 << 12) | 32'h501);
        apb_wr(8'h04, (32'd96 << 8) | 32'h2);
        repeat (60) @(negedge clk);
        apb_wr(8'h08, 32'h1);
        apb_rd(8'h04, d); chk("R11 busy cleared", d[3], 0);
        apb_rd(8'h0C, d); chk("R11 status cleared", d, 0);
        apb_rd(8'h00, d); chk("R11 cfg kept", d, (32'd3 << 12) | 32'h501);
        chk("R11 lines idle", {30'b0, ser_clk, ser_load}, 32'h2);

        // R9 disabled trigger ignored
        apb_wr(8'h00, 32'h0);
        mon_clear();
        apb_wr(8'h04, (32'd32 << 8) | 32'h2);
        repeat (100) @(negedge clk);
        chk("R9 disabled no frame", frames, 0);

        // R12 repeat mode, gap 2 then gap 0, divider 1
        for (int gi = 0; gi < 2; gi++) begin
            int g;
            g = (gi == 0) ? 2 : 0;
            apb_wr(8'h00, (32'd1 << 12) | 32'h1);
            mon_clear();
            apb_wr(8'h04, (32'(g) << 16) | (32'd32 << 8) | 32'h6);
            for (int i = 0; i < 2000 && frames < 2; i++) @(negedge clk);
            chk("R12 gap cycles", gap_meas, 2 + 1 + 2 * g * 2);
            apb_wr(8'h04, (32'(g) << 16) | (32'd32 << 8));
            wait_idle();
            f = frames;
            repeat (300) @(negedge clk);
            chk("R12 stops when cleared", frames, f);
            apb_wr(8'h0C, 32'h0);
        end

        finish_run();
    end

endmodule